// File: doc/BRIEF.md
# Write-Shadowing Memory Controller

This controller sits between a byte-wide CPU bus and two memory ports: a fast port reaching banks 00 and 01 and a slow port reaching banks E0 and E1. Fast-bank reads and writes complete in the cycle they are presented. An 8-bit shadow-enable register selects address windows. A fast-bank write inside any enabled window also goes to the slow bank at the same offset (00 goes to E0, 01 goes to E1). For that mirror, the CPU is held until the slow write has been issued on a slow-cycle enable pulse.

Accesses made directly to E0/E1, both reads and writes, are held in the same way. Accesses to any other bank complete at once and touch neither port. The CPU keeps its request, address, write flag and write data stable until it sees `cpu_ready` high. The access completes on the rising clock edge at the end of that cycle.

Top module: `shadow_write_ctl`

## Requirements
- R1: After reset the enable register reads 0x00, so no write is mirrored, and with no request pending `cpu_ready` is high while `fast_en` and `slow_en` are low.
- R2: A request to bank 00 or 01 drives `fast_en` in the cycle it is presented, with `fast_addr` = {bank bit 0, offset}. A read there never drops `cpu_ready`, even inside an enabled window, and returns `fast_rdata`.
- R3: The enable register sits at bank 00, offset 0xC035. It is read and written in one cycle with no activity on either port. Bits 5 and 7 are stored and read back but select no window.
- R4: The windows are: bit 0 covers offsets 0x0400–0x07FF; bit 1 covers 0x2000–0x3FFF; bit 2 covers 0x4000–0x5FFF; bit 3 covers 0x2000–0x9FFF; bit 4 covers 0x2000–0x3FFF in bank 01 only; bit 6 covers 0xC000–0xDFFF. A fast-bank write outside every enabled window completes in one cycle with no slow write.
- R5: A mirrored write stores the data once in fast memory during the decode cycle. It stores the same data once in slow memory at `slow_addr` = {bank bit 0, offset}, so 00 maps to E0 and 01 maps to E1.
- R6: For any access that needs the slow port, decoded in cycle c0: let t1 be the first cycle after c0 with `slow_tick` high. `cpu_ready` stays low from c0 through t1+N-1 and rises in cycle t1+N, together with `slow_en`. Here N is the tick period. The stall is N plus a phase wait of 1 to N cycles.
- R7: A direct access to E0 or E1 follows the R6 timing and never drives `fast_en`. A read returns `slow_rdata` in the completion cycle.
- R8: A request to any bank other than 00, 01, E0 or E1 completes in its first cycle. It drives neither port and reads as 0x00.
- R9: Only writes made while a matching bit is set are mirrored. Setting a bit later copies nothing already in fast memory.
- R10: When a write falls in several enabled windows, it is mirrored exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse marking each slow-cycle edge |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Bank in [23:16], offset in [15:0] |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid when ready |
| cpu_ready | output | 1 | Access completes at the end of this cycle |
| fast_en | output | 1 | Fast port strobe |
| fast_we | output | 1 | Fast port write flag |
| fast_addr | output | 17 | Fast port address {bank bit, offset} |
| fast_wdata | output | 8 | Fast port write data |
| fast_rdata | input | 8 | Fast port read data, combinational |
| slow_en | output | 1 | Slow port strobe |
| slow_we | output | 1 | Slow port write flag |
| slow_addr | output | 17 | Slow port address {bank bit, offset} |
| slow_wdata | output | 8 | Slow port write data |
| slow_rdata | input | 8 | Slow port read data, combinational |

## Verification
Single-cycle results (fast accesses, register accesses, other banks) are due in the cycle the request is presented. The bench samples `cpu_ready` and `cpu_rdata` 1 ns after driving the inputs on the falling edge. For slow-port accesses, the bench records the cycle index at decode and computes the completion cycle from its own tick schedule (first tick after decode plus N). It counts the falling edges with `cpu_ready` low and compares that count to this value. Port strobes are tallied on rising edges, so each access is judged after its completing edge and before the next one begins. Random idle gaps place decode cycles at every tick phase.

// File: rtl/shadow_write_ctl.sv
module shadow_write_ctl #(
  parameter logic [15:0] CTL_OFF   = 16'hC035,
  parameter logic [7:0]  FAST_BANK = 8'h00,
  parameter logic [7:0]  SLOW_BANK = 8'hE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [23:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_ready,
  output logic        fast_en,
  output logic        fast_we,
  output logic [16:0] fast_addr,
  output logic [7:0]  fast_wdata,
  input  logic [7:0]  fast_rdata,
  output logic        slow_en,
  output logic        slow_we,
  output logic [16:0] slow_addr,
  output logic [7:0]  slow_wdata,
  input  logic [7:0]  slow_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_XFER} st_t;

  st_t        st;
  logic [7:0] ctl;

  logic [7:0]  bank;
  logic [15:0] off;
  logic        in_fast, in_slow, is_ctl, fast_hit, win_hit, need_slow, idle, done;

  assign bank    = cpu_addr[23:16];
  assign off     = cpu_addr[15:0];
  assign in_fast = bank[7:1] == FAST_BANK[7:1];
  assign in_slow = bank[7:1] == SLOW_BANK[7:1];
  assign is_ctl  = cpu_req && bank == FAST_BANK && off == CTL_OFF;
  assign fast_hit = cpu_req && in_fast && !is_ctl;
  assign idle    = st == ST_IDLE;
  assign done    = st == ST_XFER && slow_tick;

  assign win_hit =
      (ctl[0] && off >= 16'h0400 && off <= 16'h07FF) ||
      (ctl[1] && off >= 16'h2000 && off <= 16'h3FFF) ||
      (ctl[2] && off >= 16'h4000 && off <= 16'h5FFF) ||
      (ctl[3] && off >= 16'h2000 && off <= 16'h9FFF) ||
      (ctl[4] && bank[0] && off >= 16'h2000 && off <= 16'h3FFF) ||
      (ctl[6] && off >= 16'hC000 && off <= 16'hDFFF);

  assign need_slow = (fast_hit && cpu_we && win_hit) || (cpu_req && in_slow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      ctl <= 8'h00;
    end else begin
      case (st)
        ST_IDLE: if (need_slow) st <= ST_SYNC;
        ST_SYNC: if (slow_tick) st <= ST_XFER;
        ST_XFER: if (slow_tick) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (idle && is_ctl && cpu_we) ctl <= cpu_wdata;
    end
  end

  assign cpu_ready  = idle ? !need_slow : done;

  assign fast_en    = idle && fast_hit;
  assign fast_we    = cpu_we;
  assign fast_addr  = {bank[0], off};
  assign fast_wdata = cpu_wdata;

  assign slow_en    = done;
  assign slow_we    = cpu_we;
  assign slow_addr  = {bank[0], off};
  assign slow_wdata = cpu_wdata;

  always_comb begin
    cpu_rdata = 8'h00;
    if (idle && is_ctl)            cpu_rdata = ctl;
    else if (idle && fast_hit)     cpu_rdata = fast_rdata;
    else if (done && in_slow)      cpu_rdata = slow_rdata;
  end

endmodule

module shadow_write_ctl_chk #(
  parameter logic [7:0] FAST_BANK = 8'h00,
  parameter logic [7:0] SLOW_BANK = 8'hE0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        slow_tick,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic [23:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_ready,
  input logic        fast_en,
  input logic        slow_en,
  input logic        slow_we,
  input logic [16:0] slow_addr,
  input logic [7:0]  slow_wdata
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  logic fb, sb;
  assign fb = cpu_addr[23:17] == FAST_BANK[7:1];
  assign sb = cpu_addr[23:17] == SLOW_BANK[7:1];

  assert_fast_read_nostall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_we && fb |-> cpu_ready);

  assert_strobe_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |-> slow_tick && cpu_ready);

  assert_mirror_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en && fb |-> slow_we && slow_addr == cpu_addr[16:0] && slow_wdata == cpu_wdata);

  assert_single_fast_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !cpu_ready && !$past(cpu_ready) |-> !fast_en);

  assert_slow_bank_no_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && sb |-> !fast_en);

  assert_other_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !fb && !sb |-> cpu_ready && !fast_en && !slow_en);

endmodule

bind shadow_write_ctl shadow_write_ctl_chk #(.FAST_BANK(FAST_BANK), .SLOW_BANK(SLOW_BANK)) i_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .fast_en(fast_en),
  .slow_en(slow_en), .slow_we(slow_we), .slow_addr(slow_addr), .slow_wdata(slow_wdata)
);

// File: tb/test_shadow_write_ctl.sv
`timescale 1ns/1ps
module test_shadow_write_ctl;
  localparam int N  = 5;
  localparam int PH = 2;

  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata, fast_wdata, slow_wdata, fast_rdata, slow_rdata;
  logic        cpu_ready, fast_en, fast_we, slow_en, slow_we, slow_tick;
  logic [16:0] fast_addr, slow_addr;
  int          cyc = 0, total = 0, fails = 0, fcnt = 0, scnt = 0;
  logic [7:0]  ctl_m = 8'h00;
  logic [7:0]  fcap [int];
  logic [7:0]  scap [int];
  logic [7:0]  fexp [int];
  logic [7:0]  sexp [int];

  always #10 clk = ~clk;

  function automatic logic [7:0] fpat(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] spat(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'hC3;
  endfunction

  assign slow_tick  = (cyc % N) == PH;
  assign fast_rdata = fpat(fast_addr);
  assign slow_rdata = spat(slow_addr);

  shadow_write_ctl i_shadow_write_ctl (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fast_en && fast_we) begin fcap[int'(fast_addr)] = fast_wdata; fcnt++; end
    if (slow_en && slow_we) begin scap[int'(slow_addr)] = slow_wdata; scnt++; end
    if (cyc == 150000) begin
      fails++; total++;
      $display("FAIL watchdog expired: act %0d exp below %0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %0h exp %0h", what, act, exp);
    end
  endtask

  function automatic int exp_stall(int c0);
    int t = c0 + 1;
    while (t % N != PH) t++;
    return t + N - c0;
  endfunction

  function automatic bit shadowed(logic [7:0] b, logic [15:0] o, logic [7:0] c);
    return (c[0] && o >= 16'h0400 && o <= 16'h07FF) ||
           (c[1] && o >= 16'h2000 && o <= 16'h3FFF) ||
           (c[2] && o >= 16'h4000 && o <= 16'h5FFF) ||
           (c[3] && o >= 16'h2000 && o <= 16'h9FFF) ||
           (c[4] && b == 8'h01 && o >= 16'h2000 && o <= 16'h3FFF) ||
           (c[6] && o >= 16'hC000 && o <= 16'hDFFF);
  endfunction

  task automatic acc(input logic [7:0] b, input logic [15:0] o, input bit we, input logic [7:0] d,
                     output int stall, output int c0, output logic [7:0] rd);
    repeat ($urandom_range(0, N)) @(negedge clk);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = {b, o}; cpu_wdata = d;
    c0 = cyc; stall = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; stall++; end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic set_ctl(input logic [7:0] v);
    int s, c; logic [7:0] rd; int f0 = fcnt, s0 = scnt;
    acc(8'h00, 16'hC035, 1, v, s, c, rd);
    chk(s == 0 && fcnt == f0 && scnt == s0, "R3 ctl write one cycle, no port activity", s, 0);
    ctl_m = v;
  endtask

  task automatic wr(input logic [7:0] b, input logic [15:0] o, input logic [7:0] d, input string tag);
    int s, c; logic [7:0] rd; int f0 = fcnt, s0 = scnt; bit sh;
    sh = shadowed(b, o, ctl_m);
    acc(b, o, 1, d, s, c, rd);
    fexp[int'({b[0], o})] = d;
    if (sh) sexp[int'({b[0], o})] = d;
    chk(s == (sh ? exp_stall(c) : 0), {tag, " stall"}, s, sh ? exp_stall(c) : 0);
    chk(fcnt - f0 == 1 && scnt - s0 == (sh ? 1 : 0), {tag, " strobe count"}, scnt - s0, sh ? 1 : 0);
  endtask

  logic [15:0] probes [16] = '{16'h03FF, 16'h0400, 16'h07FF, 16'h0800, 16'h1FFF, 16'h2000,
                               16'h3FFF, 16'h4000, 16'h5FFF, 16'h6000, 16'h9FFF, 16'hA000,
                               16'hBFFF, 16'hC000, 16'hDFFF, 16'hE000};
  int bits [7] = '{-1, 0, 1, 2, 3, 4, 6};

  initial begin
    int s, c; logic [7:0] rd; int f0, s0;
    repeat (3) @(negedge clk);
    #1;
    chk(cpu_ready && !fast_en && !slow_en, "R1 idle outputs in reset", {cpu_ready, fast_en, slow_en}, 3'b100);
    rst_n = 1;
    acc(8'h00, 16'hC035, 0, 8'h00, s, c, rd);
    chk(rd == 8'h00 && s == 0, "R1 ctl reset value", rd, 0);
    wr(8'h00, 16'h0400, 8'h11, "R1 no mirror after reset");

    set_ctl(8'hA0);
    acc(8'h00, 16'hC035, 0, 8'h00, s, c, rd);
    chk(rd == 8'hA0, "R3 ctl readback", rd, 8'hA0);
    wr(8'h00, 16'h2000, 8'h22, "R3 bits 5/7 select nothing");

    foreach (bits[i]) begin
      set_ctl(bits[i] < 0 ? 8'h00 : 8'(1 << bits[i]));
      for (int b = 0; b < 2; b++)
        foreach (probes[k])
          wr(8'(b), probes[k], probes[k][7:0] ^ 8'(b) ^ 8'(i), "R4 window sweep");
    end

    set_ctl(8'h5F);
    foreach (probes[k]) begin
      for (int b = 0; b < 2; b++) begin
        acc(8'(b), probes[k], 0, 8'h00, s, c, rd);
        chk(s == 0 && rd == fpat({1'(b), probes[k]}), "R2 fast read no stall", rd, fpat({1'(b), probes[k]}));
      end
    end

    set_ctl(8'h0A);
    wr(8'h00, 16'h2100, 8'h33, "R10 overlap mirrored once");
    wr(8'h01, 16'h3FFF, 8'h34, "R10 overlap bank 01");

    set_ctl(8'h00);
    wr(8'h00, 16'h0500, 8'h44, "R9 write while disabled");
    set_ctl(8'h01);
    chk(!scap.exists(int'(17'h00500)), "R9 no retroactive copy", scap.exists(int'(17'h00500)), 0);
    wr(8'h00, 16'h0501, 8'h45, "R9 write after enable");

    for (int b = 0; b < 2; b++) begin
      f0 = fcnt; s0 = scnt;
      acc(8'hE0 | 8'(b), 16'h1234, 0, 8'h00, s, c, rd);
      chk(s == exp_stall(c), "R7 slow read stall (R6 timing)", s, exp_stall(c));
      chk(rd == spat({1'(b), 16'h1234}) && fcnt == f0, "R7 slow read data", rd, spat({1'(b), 16'h1234}));
      acc(8'hE0 | 8'(b), 16'h0456, 1, 8'h5B ^ 8'(b), s, c, rd);
      sexp[int'({1'(b), 16'h0456})] = 8'h5B ^ 8'(b);
      chk(s == exp_stall(c), "R6 slow write stall", s, exp_stall(c));
      chk(fcnt == f0 && scnt - s0 == 1, "R7 slow write strobes", scnt - s0, 1);
    end

    foreach (probes[k]) begin
      f0 = fcnt; s0 = scnt;
      acc(8'h02 + 8'(k * 16), probes[k], k[0], 8'h77, s, c, rd);
      chk(s == 0 && rd == 8'h00 && fcnt == f0 && scnt == s0, "R8 other bank ignored", {s[7:0], rd}, 0);
    end

    chk(fcap.num() == fexp.num(), "R5 fast write count", fcap.num(), fexp.num());
    foreach (fexp[k]) chk(fcap.exists(k) && fcap[k] == fexp[k], "R5 fast memory content",
                          fcap.exists(k) ? int'(fcap[k]) : -1, fexp[k]);
    chk(scap.num() == sexp.num(), "R5 slow write count", scap.num(), sexp.num());
    foreach (sexp[k]) chk(scap.exists(k) && scap[k] == sexp[k], "R5 slow memory content",
                          scap.exists(k) ? int'(scap[k]) : -1, sexp[k]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule